// File: doc/BRIEF.md
# Receive Code-Group Aligner and 5B/4B Decoder

This block sits between a descrambler and a MAC-facing receive interface. It takes one descrambled bit per valid-bit strobe and a lock indication. While no frame is in progress it slides a ten-bit window over the stream and looks for the start-of-stream delimiter, the code-group pair J then K. The bit position where that pair ends fixes the 5-bit code-group boundary, and the block keeps that boundary until the frame ends.

Within a frame every five valid bits form one code-group. Each code-group is translated into a 4-bit nibble and presented on `rxd` with a one-cycle `nib_stb` pulse. The delimiter pair itself becomes two preamble nibbles. A frame ends on the end-of-stream pair T then R, or on two IDLE code-groups in a row, and neither is passed on as data. Output runs one code-group behind the input, so the block can recognise an ending pair before any part of it reaches `rxd`.

Top module: `cgdec_rx`

## Requirements
- R1: After reset `rxd` is 0000 and `rx_dv`, `crs`, `rx_err` and `nib_stb` are 0.
- R2: While no frame is in progress and `lock` is 1, a frame starts on the valid bit that completes the bit sequence 1100010001 (earliest bit leftmost; J = 11000, K = 10001), at any bit offset. From then on, every 5 valid bits form one code-group, with the earliest bit as the MSB.
- R3: On the bit that completes the delimiter, the block strobes `rxd` = 0101 with `rx_dv` = `crs` = 1 and `rx_err` = 0. It strobes a second 0101 nibble when the first code-group after the delimiter completes.
- R4: Data code-groups map to nibbles as 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101. Each nibble is strobed when the next code-group completes.
- R5: T (01101) followed by R (00111) ends the frame. The strobe on the R code-group carries `rx_dv` = `crs` = `rx_err` = 0 and `rxd` = 0000, and T never appears as data.
- R6: Two consecutive I code-groups (11111) end the frame the same way, with the end strobe on the second I.
- R7: Inside a frame, any code-group that is not data and is not part of an ending pair is strobed with `rx_err` = 1 and `rxd` = 0000 while `rx_dv` stays 1. The frame continues.
- R8: While `lock` is 0, a delimiter in the stream starts no frame and produces no strobe.
- R9: `nib_stb` lasts one cycle, occurs only right after a valid-bit cycle, and `rxd` changes only together with a strobe.
- R10: If `lock` falls during a frame, `rx_dv`, `crs` and `rx_err` are 0 on the next clock with no strobe, `rxd` keeps its value, and the block returns to delimiter search.
- R11: Cycles with `bit_vld` = 0 advance nothing. The nibble sequence does not depend on gaps between valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_vld | input | 1 | Qualifies `bit_in` this cycle |
| bit_in | input | 1 | Descrambled serial bit |
| lock | input | 1 | Descrambler lock indication |
| rxd | output | 4 | Decoded receive nibble |
| rx_dv | output | 1 | Receive data valid |
| crs | output | 1 | Carrier sense |
| rx_err | output | 1 | Receive error for the current nibble |
| nib_stb | output | 1 | One-cycle nibble strobe |

## Verification
A wrong code-group boundary shows up at the first data nibble after the delimiter: the nibble either decodes to a wrong value or is flagged as an error, one code-group time after the second preamble nibble. A framing state stuck in the frame stays visible as `rx_dv` held high past a T/R or I/I ending, and a stuck search state shows as a missing preamble strobe. An inverted lock priority appears as a strobe on the cycle after lock falls. The scoreboard compares every strobe with the expected value, so a single extra or missing nibble breaks the sequence at once.

// File: rtl/cgdec_pkg.sv
package cgdec_pkg;

   localparam int CG_BITS  = 5;
   localparam int NIB_BITS = 4;

   localparam logic [CG_BITS-1:0] CG_J = 5'b11000;
   localparam logic [CG_BITS-1:0] CG_K = 5'b10001;
   localparam logic [CG_BITS-1:0] CG_T = 5'b01101;
   localparam logic [CG_BITS-1:0] CG_R = 5'b00111;
   localparam logic [CG_BITS-1:0] CG_I = 5'b11111;

   typedef enum logic [2:0] {
      SK_DATA = 3'd0,
      SK_IDLE = 3'd1,
      SK_T    = 3'd2,
      SK_R    = 3'd3,
      SK_BAD  = 3'd4
   } sym_kind_e;

   typedef struct packed {
      sym_kind_e             kind;
      logic [NIB_BITS-1:0]   nib;
   } sym_t;

   function automatic sym_t classify(input logic [CG_BITS-1:0] cg);
      sym_t s;
      s.kind = SK_DATA;
      s.nib  = '0;
      case (cg)
         5'b11110: s.nib = 4'h0;
         5'b01001: s.nib = 4'h1;
         5'b10100: s.nib = 4'h2;
         5'b10101: s.nib = 4'h3;
         5'b01010: s.nib = 4'h4;
         5'b01011: s.nib = 4'h5;
         5'b01110: s.nib = 4'h6;
         5'b01111: s.nib = 4'h7;
         5'b10010: s.nib = 4'h8;
         5'b10011: s.nib = 4'h9;
         5'b10110: s.nib = 4'hA;
         5'b10111: s.nib = 4'hB;
         5'b11010: s.nib = 4'hC;
         5'b11011: s.nib = 4'hD;
         5'b11100: s.nib = 4'hE;
         5'b11101: s.nib = 4'hF;
         CG_I:     s.kind = SK_IDLE;
         CG_T:     s.kind = SK_T;
         CG_R:     s.kind = SK_R;
         default:  s.kind = SK_BAD;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/cgdec_window.sv
module cgdec_window import cgdec_pkg::*; #(
   parameter int CG_W = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bit_vld,
   input  logic            bit_in,
   input  logic            search_en,
   output logic            ssd_hit,
   output logic            grp_done,
   output logic [CG_W-1:0] grp
);

   localparam int WIN_W = 2 * CG_W;
   localparam int CNT_W = $clog2(CG_W);
   localparam logic [WIN_W-1:0] SSD_PAT = {CG_J, CG_K};

   logic [WIN_W-2:0] hist_q;
   logic [WIN_W-1:0] win;
   logic [WIN_W-1:0] eq;
   logic [CNT_W-1:0] pos_q;

   assign win = {hist_q, bit_in};

   for (genvar gi = 0; gi < WIN_W; gi++) begin : g_cmp
      assign eq[gi] = (win[gi] == SSD_PAT[gi]);
   end

   assign ssd_hit  = bit_vld && search_en && (&eq);
   assign grp_done = bit_vld && (pos_q == CNT_W'(CG_W - 1));
   assign grp      = win[CG_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         pos_q  <= '0;
      end else if (bit_vld) begin
         hist_q <= win[WIN_W-2:0];
         if (ssd_hit || pos_q == CNT_W'(CG_W - 1))
            pos_q <= '0;
         else
            pos_q <= pos_q + 1'b1;
      end
   end

endmodule

// File: rtl/cgdec_sym.sv
module cgdec_sym import cgdec_pkg::*; #(
   parameter int CG_W = 5
) (
   input  logic [CG_W-1:0] grp,
   output sym_t            sym
);

   always_comb sym = classify(grp);

endmodule

// File: rtl/cgdec_frame.sv
module cgdec_frame import cgdec_pkg::*; #(
   parameter int          NIB_W   = 4,
   parameter logic [3:0]  PRE_NIB = 4'b0101,
   parameter logic [3:0]  ERR_NIB = 4'b0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock,
   input  logic             bit_vld,
   input  logic             ssd_hit,
   input  logic             grp_done,
   input  sym_t             sym,
   output logic             hunting,
   output logic [NIB_W-1:0] rxd,
   output logic             rx_dv,
   output logic             crs,
   output logic             rx_err,
   output logic             nib_stb
);

   typedef enum logic {ST_HUNT, ST_FRAME} fr_state_e;

   fr_state_e state_q;
   sym_t      held_q;
   logic      held_pre_q;
   logic      pair_end;

   assign hunting = (state_q == ST_HUNT);
   assign crs     = rx_dv;

   always_comb begin
      pair_end = 1'b0;
      if (!held_pre_q) begin
         if (held_q.kind == SK_T && sym.kind == SK_R)       pair_end = 1'b1;
         if (held_q.kind == SK_IDLE && sym.kind == SK_IDLE) pair_end = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_HUNT;
         held_q     <= '0;
         held_pre_q <= 1'b0;
         rxd        <= '0;
         rx_dv      <= 1'b0;
         rx_err     <= 1'b0;
         nib_stb    <= 1'b0;
      end else begin
         nib_stb <= 1'b0;
         if (state_q == ST_HUNT) begin
            if (ssd_hit) begin
               state_q    <= ST_FRAME;
               held_pre_q <= 1'b1;
               rxd        <= PRE_NIB;
               rx_dv      <= 1'b1;
               rx_err     <= 1'b0;
               nib_stb    <= 1'b1;
            end
         end else if (!lock) begin
            state_q <= ST_HUNT;
            rx_dv   <= 1'b0;
            rx_err  <= 1'b0;
         end else if (grp_done) begin
            nib_stb <= 1'b1;
            if (pair_end) begin
               state_q <= ST_HUNT;
               rxd     <= '0;
               rx_dv   <= 1'b0;
               rx_err  <= 1'b0;
            end else begin
               if (held_pre_q) begin
                  rxd    <= PRE_NIB;
                  rx_err <= 1'b0;
               end else if (held_q.kind == SK_DATA) begin
                  rxd    <= held_q.nib;
                  rx_err <= 1'b0;
               end else begin
                  rxd    <= ERR_NIB;
                  rx_err <= 1'b1;
               end
               held_pre_q <= 1'b0;
               held_q     <= sym;
            end
         end
      end
   end

   AST_STB_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      nib_stb |-> $past(bit_vld)); // R9
   AST_RXD_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
      !nib_stb |-> $stable(rxd)); // R9
   AST_LOCK_LOSS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_dv && !lock) |=> (!rx_dv && !nib_stb && !rx_err)); // R10
   AST_ERR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      rx_err |-> rx_dv); // R7
   AST_START_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_dv) |-> (nib_stb && rxd == PRE_NIB && !rx_err)); // R3
   AST_END_HAS_STB: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rx_dv) && $past(lock)) |-> (nib_stb && rxd == '0)); // R5

endmodule

// File: rtl/cgdec_rx.sv
module cgdec_rx import cgdec_pkg::*; #(
   parameter int          CG_W    = 5,
   parameter int          NIB_W   = 4,
   parameter logic [3:0]  PRE_NIB = 4'b0101,
   parameter logic [3:0]  ERR_NIB = 4'b0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld,
   input  logic             bit_in,
   input  logic             lock,
   output logic [NIB_W-1:0] rxd,
   output logic             rx_dv,
   output logic             crs,
   output logic             rx_err,
   output logic             nib_stb
);

   if (CG_W != CG_BITS) begin : g_bad_cg_w
      $error("cgdec_rx: CG_W must equal the 5-bit code-group width");
   end
   if (NIB_W != NIB_BITS) begin : g_bad_nib_w
      $error("cgdec_rx: NIB_W must equal the 4-bit nibble width");
   end

   logic            hunting;
   logic            ssd_hit;
   logic            grp_done;
   logic [CG_W-1:0] grp;
   sym_t            sym;

   cgdec_window #(.CG_W(CG_W)) u_window (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_vld   (bit_vld),
      .bit_in    (bit_in),
      .search_en (hunting && lock),
      .ssd_hit   (ssd_hit),
      .grp_done  (grp_done),
      .grp       (grp)
   );

   cgdec_sym #(.CG_W(CG_W)) u_sym (
      .grp (grp),
      .sym (sym)
   );

   cgdec_frame #(
      .NIB_W   (NIB_W),
      .PRE_NIB (PRE_NIB),
      .ERR_NIB (ERR_NIB)
   ) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock     (lock),
      .bit_vld  (bit_vld),
      .ssd_hit  (ssd_hit),
      .grp_done (grp_done),
      .sym      (sym),
      .hunting  (hunting),
      .rxd      (rxd),
      .rx_dv    (rx_dv),
      .crs      (crs),
      .rx_err   (rx_err),
      .nib_stb  (nib_stb)
   );

   AST_NO_START_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_dv && !lock) |=> !rx_dv); // R8

endmodule

// File: tb/cgdec_rx_bench.sv
`timescale 1ns/1ps
module cgdec_rx_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_vld = 1'b0;
   logic       bit_in = 1'b0;
   logic       lock = 1'b0;
   logic [3:0] rxd;
   logic       rx_dv, crs, rx_err, nib_stb;

   always #2.5 clk = ~clk;

   cgdec_rx u_cgdec_rx (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in), .lock(lock),
      .rxd(rxd), .rx_dv(rx_dv), .crs(crs), .rx_err(rx_err), .nib_stb(nib_stb)
   );

   typedef struct { logic [6:0] v; string req; } exp_t;
   exp_t q[$];

   int n_chk = 0;
   int n_fail = 0;
   int bit_n = 0;
   bit finished = 1'b0;
   logic prev_stb = 1'b0;

   task automatic chk(bit ok, string req, string what, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   function automatic logic [4:0] enc(input logic [3:0] n);
      case (n)
         4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001;
         4'h2: enc = 5'b10100; 4'h3: enc = 5'b10101;
         4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011;
         4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111;
         4'h8: enc = 5'b10010; 4'h9: enc = 5'b10011;
         4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
         4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011;
         4'hE: enc = 5'b11100; default: enc = 5'b11101;
      endcase
   endfunction

   task automatic expect_nib(logic dv, logic er, logic [3:0] n, string req);
      exp_t e;
      e.v = {dv, dv, er, n};
      e.req = req;
      q.push_back(e);
   endtask

   // R11: gaps of bit_vld = 0 are inserted every third bit
   task automatic send_bit(logic b);
      @(negedge clk);
      bit_in = b;
      bit_vld = 1'b1;
      bit_n++;
      if (bit_n % 3 == 0) begin
         @(negedge clk);
         bit_vld = 1'b0;
      end
   endtask

   task automatic send_grp(logic [4:0] g);
      for (int i = 4; i >= 0; i--) send_bit(g[i]);
   endtask

   task automatic quiet(int n);
      @(negedge clk);
      bit_vld = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_ssd(bit expect_it);
      if (expect_it) expect_nib(1'b1, 1'b0, 4'b0101, "R3");
      send_grp(5'b11000);
      send_grp(5'b10001);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (nib_stb && prev_stb) chk(1'b0, "R9", "strobe longer than one cycle", 1, 0);
         if (nib_stb) begin
            if (q.size() == 0) begin
               chk(1'b0, "R8", "unexpected strobe", {rx_dv, crs, rx_err, rxd}, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk({rx_dv, crs, rx_err, rxd} == e.v, e.req, "nibble {dv,crs,err,rxd}",
                   {rx_dv, crs, rx_err, rxd}, e.v);
            end
         end
         prev_stb = nib_stb;
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      chk({rxd, rx_dv, crs, rx_err, nib_stb} == 8'h00, "R1", "reset outputs",
          {rxd, rx_dv, crs, rx_err, nib_stb}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({rxd, rx_dv, crs, rx_err, nib_stb} == 8'h00, "R1", "after reset release",
          {rxd, rx_dv, crs, rx_err, nib_stb}, 0);
      lock = 1'b1;

      // R2 + R4 + R5: odd bit offset, all 16 data codes, T/R ending
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      repeat (3) send_grp(5'b11111);
      send_ssd(1'b1);
      expect_nib(1'b1, 1'b0, 4'b0101, "R3");
      for (int n = 0; n < 16; n++) begin
         send_grp(enc(4'(n)));
         if (n > 0) expect_nib(1'b1, 1'b0, 4'(n - 1), "R4");
      end
      expect_nib(1'b1, 1'b0, 4'hF, "R4");
      send_grp(5'b01101);
      expect_nib(1'b0, 1'b0, 4'h0, "R5");
      send_grp(5'b00111);
      quiet(3);
      chk(rx_dv == 1'b0 && crs == 1'b0, "R5", "dv/crs low after T/R", {rx_dv, crs}, 0);
      repeat (2) send_grp(5'b11111);

      // R6: end on two IDLE code-groups
      send_ssd(1'b1);
      expect_nib(1'b1, 1'b0, 4'b0101, "R3");
      send_grp(enc(4'h5));
      expect_nib(1'b1, 1'b0, 4'h5, "R4");
      send_grp(enc(4'hA));
      expect_nib(1'b1, 1'b0, 4'hA, "R4");
      send_grp(enc(4'h3));
      expect_nib(1'b1, 1'b0, 4'h3, "R6");
      send_grp(5'b11111);
      expect_nib(1'b0, 1'b0, 4'h0, "R6");
      send_grp(5'b11111);
      quiet(3);
      chk(rx_dv == 1'b0, "R6", "dv low after I/I", rx_dv, 0);
      send_grp(5'b11111);

      // R7: invalid code-group inside a frame
      send_ssd(1'b1);
      expect_nib(1'b1, 1'b0, 4'b0101, "R3");
      send_grp(enc(4'h1));
      expect_nib(1'b1, 1'b0, 4'h1, "R7");
      send_grp(5'b00000);
      expect_nib(1'b1, 1'b1, 4'h0, "R7");
      send_grp(enc(4'h7));
      expect_nib(1'b1, 1'b0, 4'h7, "R7");
      send_grp(5'b01101);
      expect_nib(1'b0, 1'b0, 4'h0, "R5");
      send_grp(5'b00111);
      quiet(3);
      chk(rx_err == 1'b0 && rx_dv == 1'b0, "R7", "err cleared at frame end", {rx_dv, rx_err}, 0);

      // R8: delimiter ignored without lock
      lock = 1'b0;
      repeat (2) send_grp(5'b11111);
      send_ssd(1'b0);
      send_grp(enc(4'h2));
      send_grp(enc(4'h4));
      quiet(3);
      chk(rx_dv == 1'b0 && crs == 1'b0, "R8", "no frame without lock", {rx_dv, crs}, 0);
      chk(q.size() == 0, "R8", "pending expectations", q.size(), 0);

      // R10: lock loss mid frame, then recovery
      lock = 1'b1;
      repeat (3) send_grp(5'b11111);
      send_ssd(1'b1);
      expect_nib(1'b1, 1'b0, 4'b0101, "R3");
      send_grp(enc(4'h2));
      expect_nib(1'b1, 1'b0, 4'h2, "R10");
      send_grp(enc(4'h4));
      expect_nib(1'b1, 1'b0, 4'h4, "R10");
      send_grp(enc(4'h6));
      @(negedge clk);
      bit_vld = 1'b0;
      lock = 1'b0;
      repeat (2) @(negedge clk);
      chk(rx_dv == 1'b0 && crs == 1'b0 && rx_err == 1'b0, "R10", "dv/crs/err after lock loss",
          {rx_dv, crs, rx_err}, 0);
      chk(rxd == 4'h4, "R10", "rxd held after lock loss", rxd, 4'h4);
      send_grp(5'b01101);
      send_grp(5'b00111);
      quiet(2);
      lock = 1'b1;
      repeat (3) send_grp(5'b11111);
      send_ssd(1'b1);
      expect_nib(1'b1, 1'b0, 4'b0101, "R2");
      send_grp(enc(4'h9));
      expect_nib(1'b1, 1'b0, 4'h9, "R2");
      send_grp(5'b01101);
      expect_nib(1'b0, 1'b0, 4'h0, "R5");
      send_grp(5'b00111);
      quiet(4);

      // R9 / R11: every expected nibble was seen, none left over
      chk(q.size() == 0, "R11", "unconsumed expectations", q.size(), 0);
      summary();
   end

endmodule